// File: doc/BRIEF.md
# Triplicated Strobe Delay Aligner

This block shifts a frame-marking valid strobe later in time so that it lines up with the digitized samples that reach the output some cycles after the strobe. The front-end chip raises its strobe at about the same time as its analogue samples. The conversion path adds a fixed latency to the samples, so a fixed delay of 8 cycles of the 25 ns clock (200 ns) is all the alignment the strobe needs. An 8-bit sample input passes through a single register unchanged. The block then presents each sample together with the strobe that has been re-timed for it.

The delay line is built for a radiation environment. Every stage holds three copies of the strobe bit, and the value a stage passes on is the majority of its three copies. At every clock, all three copies of a stage load the voted value of the stage before it. An upset in a single copy is therefore outvoted at once and overwritten at the next edge. An error flag is raised for each cycle in which the copies at any stage disagree. Upsets can be injected on purpose through a small set of test pins.

The block has no flow control. It takes one strobe bit and one sample in every clock cycle and cannot stall. A downstream consumer must accept one output per cycle.

Top module: `strobe_align_tmr`

## Requirements
- R1: A level on `in_valid` during one cycle appears on `out_valid` exactly 8 cycles later. The output shows what the input showed 8 cycles before, with no stage missing or added.
- R2: `out_sample` equals the `in_sample` value of the previous cycle, bit for bit.
- R3: While `rst` is high at a clock edge, all copies of every stage clear to 0, and `in_valid` is not captured. After that edge `out_valid` and `tmr_err` are 0, and `out_valid` stays 0 until a strobe captured after reset has travelled the full 8 stages.
- R4: An upset in one copy, at any stage, never changes `out_valid` in any cycle.
- R5: An injection with `seu_en` high and `seu_copy` set to 0, 1 or 2 stores the inverse of the voted value into that copy of stage `seu_stage` (stage 0 is nearest the input, stage 7 drives the output). `tmr_err` is 1 in the cycle right after that edge.
- R6: The copies refresh at every edge, so `tmr_err` is 0 in any cycle that does not directly follow an injection edge.
- R7: Gaps between events survive the delay. A single idle cycle between two strobes at the input appears as a single idle cycle at the output, 8 cycles later.
- R8: An injection with `seu_copy` = 3 selects no copy, and it has no effect. `tmr_err` stays 0 and `out_valid` keeps its delayed value.
- R9: A strobe held high for many cycles in a row is accepted every cycle and comes out as an unbroken run of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame strobe from the front end |
| in_sample | input | 8 | Digitized sample |
| seu_en | input | 1 | Test upset enable |
| seu_copy | input | 2 | Copy to upset (0..2; 3 = none) |
| seu_stage | input | 3 | Stage to upset (0 = input end) |
| out_valid | output | 1 | Voted strobe, delayed by 8 cycles |
| out_sample | output | 8 | Sample, delayed by 1 cycle |
| tmr_err | output | 1 | Copies disagree at some stage |

## Verification
The properties assume that no more than one copy per stage is wrong at any time. The test pins can flip only one copy of one stage per cycle, and each flip is cleared at the next edge, so stimulus driven only through those pins never breaks the assumption. They also assume that `seu_stage` names an existing stage, which always holds at the default depth of 8. The stimulus sweeps every copy at every stage, with both strobe levels in the line. It also includes a no-copy selection, and a reset applied while strobes are in flight.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int NCOPY = 3;

  function automatic logic maj3(input logic [NCOPY-1:0] c);
    return (c[0] & c[1]) | (c[1] & c[2]) | (c[0] & c[2]);
  endfunction

  function automatic logic split3(input logic [NCOPY-1:0] c);
    return (c != '0) && (c != '1);
  endfunction
endpackage

// File: rtl/sa_tmr_cell.sv
module sa_tmr_cell
  import sa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             d,
  input  logic [NCOPY-1:0] flip,
  output logic             q,
  output logic             split
);
  logic [NCOPY-1:0] cp;

  always_ff @(posedge clk) begin
    if (rst) cp <= '0;
    else     cp <= {NCOPY{d}} ^ flip;
  end

  assign q     = maj3(cp);
  assign split = split3(cp);
endmodule

// File: rtl/sa_sample_reg.sv
module sa_sample_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/strobe_align_tmr.sv
module strobe_align_tmr
  import sa_pkg::*;
#(
  parameter  int DEPTH    = 8,
  parameter  int SAMPLE_W = 8,
  localparam int SEL_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                seu_en,
  input  logic [1:0]          seu_copy,
  input  logic [SEL_W-1:0]    seu_stage,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                tmr_err
);
  logic [DEPTH-1:0] voted;
  logic [DEPTH-1:0] split;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic [NCOPY-1:0] flip_k;
    logic             d_k;

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      assign flip_k[c] = seu_en && (seu_copy == 2'(c)) && (seu_stage == SEL_W'(k));
    end

    if (k == 0) begin : g_head
      assign d_k = in_valid;
    end else begin : g_link
      assign d_k = voted[k-1];
    end

    sa_tmr_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .d     (d_k),
      .flip  (flip_k),
      .q     (voted[k]),
      .split (split[k])
    );
  end

  sa_sample_reg #(.W(SAMPLE_W)) u_smp (
    .clk (clk),
    .d   (in_sample),
    .q   (out_sample)
  );

  assign out_valid = voted[DEPTH-1];
  assign tmr_err   = |split;
endmodule

// File: rtl/sa_tmr_chk.sv
module sa_tmr_chk #(
  parameter  int DEPTH    = 8,
  parameter  int SAMPLE_W = 8,
  localparam int SEL_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                seu_en,
  input logic [1:0]          seu_copy,
  input logic [SEL_W-1:0]    seu_stage,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_sample,
  input logic                tmr_err
);
  logic [DEPTH-1:0] hist;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DEPTH-2:0], in_valid};
  end

  assign hit = seu_en && (seu_copy != 2'd3);

  // R1 R4
  delay_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == hist[DEPTH-1]);

  // R2
  sample_pass_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_sample == $past(in_sample));

  // R5
  err_after_flip_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> tmr_err);

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !tmr_err);
endmodule

bind strobe_align_tmr sa_tmr_chk #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .seu_en     (seu_en),
  .seu_copy   (seu_copy),
  .seu_stage  (seu_stage),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .tmr_err    (tmr_err)
);

// File: tb/sim_strobe_align_tmr.sv
`timescale 1ns/1ps
module sim_strobe_align_tmr;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] in_sample;
  logic       seu_en;
  logic [1:0] seu_copy;
  logic [2:0] seu_stage;
  logic       out_valid;
  logic [7:0] out_sample;
  logic       tmr_err;

  int checks = 0;
  int fails  = 0;
  logic [7:0] bh = '0;

  always #5 clk = ~clk;

  strobe_align_tmr u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .seu_en(seu_en), .seu_copy(seu_copy), .seu_stage(seu_stage),
    .out_valid(out_valid), .out_sample(out_sample), .tmr_err(tmr_err)
  );

  // entry: {inject, copy[1:0], stage[2:0], valid, sample[7:0]}
  localparam logic [14:0] VEC [24] = '{
    {1'b0,2'd0,3'd0,1'b1,8'h11}, {1'b0,2'd0,3'd0,1'b1,8'h22},
    {1'b1,2'd0,3'd0,1'b1,8'h33}, {1'b0,2'd0,3'd0,1'b0,8'h44},
    {1'b0,2'd0,3'd0,1'b1,8'h55}, {1'b1,2'd1,3'd7,1'b1,8'h66},
    {1'b0,2'd0,3'd0,1'b0,8'h77}, {1'b0,2'd0,3'd0,1'b0,8'h88},
    {1'b0,2'd0,3'd0,1'b1,8'h99}, {1'b1,2'd2,3'd3,1'b0,8'hAA},
    {1'b0,2'd0,3'd0,1'b1,8'hBB}, {1'b0,2'd0,3'd0,1'b1,8'hCC},
    {1'b0,2'd0,3'd0,1'b1,8'hDD}, {1'b1,2'd1,3'd5,1'b1,8'hEE},
    {1'b0,2'd0,3'd0,1'b0,8'hFF}, {1'b0,2'd0,3'd0,1'b1,8'h01},
    {1'b0,2'd0,3'd0,1'b0,8'h02}, {1'b1,2'd3,3'd2,1'b0,8'h03},
    {1'b0,2'd0,3'd0,1'b1,8'h04}, {1'b0,2'd0,3'd0,1'b1,8'h05},
    {1'b1,2'd0,3'd6,1'b0,8'h06}, {1'b0,2'd0,3'd0,1'b1,8'h07},
    {1'b0,2'd0,3'd0,1'b1,8'h08}, {1'b0,2'd0,3'd0,1'b0,8'h09}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [7:0] s,
                      input logic en, input logic [1:0] cp, input logic [2:0] st,
                      input string vtag);
    logic  exp_err;
    string etag;
    @(negedge clk);
    rst = r; in_valid = v; in_sample = s;
    seu_en = en; seu_copy = cp; seu_stage = st;
    @(posedge clk);
    #2;
    if (r) bh = '0;
    else   bh = {bh[6:0], v};
    exp_err = !r && en && (cp != 2'd3);
    etag = (en && cp == 2'd3) ? "R8" : (exp_err ? "R5" : "R6");
    chk(vtag, out_valid, bh[7]);
    chk("R2", out_sample, s);
    chk(r ? "R3" : etag, tmr_err, exp_err);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    seu_en = 1'b0; seu_copy = 2'd0; seu_stage = 3'd0;
    // R3 reset state
    step(1, 0, 8'h00, 0, 0, 0, "R3");
    step(1, 1, 8'h5A, 0, 0, 0, "R3");

    // vector table (R1, R4, R5, R6, R8), then flush
    for (int i = 0; i < 32; i++) begin
      if (i < 24)
        step(0, VEC[i][8], VEC[i][7:0], VEC[i][14], VEC[i][13:12], VEC[i][11:9], "R1");
      else
        step(0, 0, 8'(i), 0, 0, 0, "R1");
    end

    // R4 flip sweep over every copy and stage, line holding both levels
    for (int st = 0; st < 8; st++) begin
      for (int cp = 0; cp < 3; cp++) begin
        step(0, 1'((st + cp) & 1), 8'(st * 3 + cp), 1, 2'(cp), 3'(st), "R4");
        step(0, 1'(st & 1), 8'hC3, 0, 0, 0, "R4");
      end
    end

    // R3 reset while strobes are in flight
    for (int i = 0; i < 5; i++) step(0, 1, 8'h10, 0, 0, 0, "R1");
    step(1, 1, 8'h20, 0, 0, 0, "R3");
    for (int i = 0; i < 9; i++) step(0, 0, 8'h30, 0, 0, 0, "R3");

    // R7 single idle gap between two events
    step(0, 1, 8'h41, 0, 0, 0, "R7");
    step(0, 0, 8'h42, 0, 0, 0, "R7");
    step(0, 1, 8'h43, 0, 0, 0, "R7");
    for (int i = 0; i < 9; i++) step(0, 0, 8'h44, 0, 0, 0, "R7");

    // R8 no-copy selection at every stage
    for (int st = 0; st < 8; st++) step(0, 1, 8'h50, 1, 2'd3, 3'(st), "R8");

    // R9 long unbroken run
    for (int i = 0; i < 12; i++) step(0, 1, 8'h60, 0, 0, 0, "R9");
    for (int i = 0; i < 10; i++) step(0, 0, 8'h61, 0, 0, 0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule